// File: doc/BRIEF.md
# Time-Multiplexed Feedforward Network Engine

This block evaluates a small fully connected feedforward network using a single multiply-accumulate datapath. A pulse on `start` latches the primary input vector. The controller then walks every layer, every neuron of that layer and every input of that neuron, one product per clock. The weights and biases are compile-time constants held in flat tables. For each step the controller forms the table index from its three counters.

When a neuron's last input has been folded in, the bias is added and a saturating rectifier is applied. The 8-bit result is written into one of two layer register banks. The banks swap roles from layer to layer. The first layer reads the latched primary inputs, and every later layer reads the bank the previous layer wrote. After the final neuron of the last layer is stored, `done` pulses for one cycle and `y_out` carries the network outputs.

The stored weights are the true weights divided by 2^WSHIFT. This keeps the multiplier narrow. Each product is shifted left by WSHIFT before it is accumulated, which restores the true scale.

Top module: `mac_net_seq`

## Requirements
- R1: After reset `done` is 0, every byte of `y_out` is 0 and the engine is idle.
- R2: A `start` seen while idle begins a run. `done` is high in exactly one cycle, which is the 18th rising edge after the edge that accepted `start`. This count is the sum over layers of inputs × neurons (4×3 + 3×2).
- R3: The primary inputs are latched on the edge that accepts `start`. Later changes to `x_in` during a run have no effect on the result. Input i is the signed byte `x_in[8i+7:8i]`.
- R4: `start` asserted while a run is in progress is ignored. The run neither restarts nor changes its timing.
- R5: Each neuron computes s = bias + Σ input_i × weight_i. It then takes s arithmetically shifted right by 3 and clamps the result to the range 0..127. Output neuron k of the last layer appears as the byte `y_out[8k+7:8k]`.
- R6: The multiplier sees stored weights equal to the true weight divided by 2^1. Results equal those computed with the true weights, which are the stored weights times 2.
- R7: The accumulator starts from zero at the first input of every neuron. A repeated run on the same vector gives the same outputs, whatever ran before.
- R8: Layer 2 takes its inputs from the stored outputs of layer 1. It never reads a value written by its own layer.
- R9: After `done`, `y_out` holds its value until a new run writes the last layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run (accepted only when idle) |
| x_in | input | 32 | Four signed 8-bit primary inputs |
| y_out | output | 16 | Two 8-bit network outputs |
| done | output | 1 | One-cycle pulse when the outputs are complete |

## Verification
The bench compares results against a bench-side integer model with full-scale weights. It uses vectors at both saturation ends (all +127, all −128), all zeros, and random patterns. A wrong shift restore or a wrong clamp shows up in those comparisons. A mistimed counter wrap or a dropped bias shows up as wrong bytes or a shifted `done` cycle.

A disturbed run changes `x_in` and pulses `start` in the middle of a run. A design that restarted or read `x_in` live would finish late or return the second vector's result. Repeated runs with large and then small inputs expose an accumulator that fails to clear. A bank swap error corrupts the second layer's inputs and breaks every comparison.

// File: rtl/nnseq_pkg.sv
// Shared constants for the time-multiplexed network engine.
// Assumes a fixed topology given by LAYER_W (inputs, hidden, outputs).
package nnseq_pkg;
    localparam int DATA_W     = 8;
    localparam int NUM_LAYERS = 2;
    localparam int LAYER_W [0:NUM_LAYERS] = '{4, 3, 2};
    localparam int WQ_W       = 5;   // stored (pre-shifted) weight width
    localparam int WSHIFT     = 1;   // common power-of-two factor of all weights
    localparam int BIAS_W     = 9;
    localparam int ACT_SHIFT  = 3;

    function automatic int max_width();
        int m = 0;
        for (int l = 0; l <= NUM_LAYERS; l++) if (LAYER_W[l] > m) m = LAYER_W[l];
        return m;
    endfunction

    function automatic int w_base(int layer);
        int s = 0;
        for (int l = 0; l < layer; l++) s += LAYER_W[l] * LAYER_W[l+1];
        return s;
    endfunction

    function automatic int b_base(int layer);
        int s = 0;
        for (int l = 0; l < layer; l++) s += LAYER_W[l+1];
        return s;
    endfunction

    // Stored weight: true weight divided by 2**WSHIFT.
    function automatic int stored_weight(int idx);
        return ((idx * 7 + 3) % 11) - 5;
    endfunction

    function automatic int bias_val(int idx);
        return (((idx * 29 + 5) % 41) - 20) * 4;
    endfunction

    localparam int MAX_W      = max_width();
    localparam int TOTAL_W    = w_base(NUM_LAYERS);
    localparam int TOTAL_B    = b_base(NUM_LAYERS);
    localparam int RUN_CYCLES = TOTAL_W;
    localparam int NUM_IN     = LAYER_W[0];
    localparam int NUM_OUT    = LAYER_W[NUM_LAYERS];
    localparam int CNT_W      = $clog2(MAX_W + 1);
    localparam int RD_W       = $clog2(MAX_W);
    localparam int LYR_W      = $clog2(NUM_LAYERS + 1);
    localparam int WIDX_W     = $clog2(TOTAL_W);
    localparam int BIDX_W     = $clog2(TOTAL_B);
    localparam int ACC_W      = DATA_W + WQ_W + WSHIFT + $clog2(MAX_W) + 3;
    localparam int ACT_MAX    = (1 << (DATA_W - 1)) - 1;
endpackage

// File: rtl/nnseq_ctrl.sv
// Sequencer: three nested counters (layer, neuron, input) that step the
// shared MAC once per cycle and form the weight and bias table indices.
// Assumes start is ignored while a run is active.
module nnseq_ctrl
    import nnseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              load,
    output logic [LYR_W-1:0]  lyr,
    output logic [CNT_W-1:0]  nrn,
    output logic [CNT_W-1:0]  inp,
    output logic              first,
    output logic              last,
    output logic [WIDX_W-1:0] w_idx,
    output logic [BIDX_W-1:0] b_idx,
    output logic              done
);
    logic [CNT_W-1:0] cur_nin, cur_nout;
    int               cur_wb, cur_bb;
    logic             last_nrn, last_lyr;

    // Look up the shape and table offsets of the current layer.
    always_comb begin
        cur_nin  = '0;
        cur_nout = '0;
        cur_wb   = 0;
        cur_bb   = 0;
        for (int l = 0; l < NUM_LAYERS; l++) begin
            if (lyr == LYR_W'(l)) begin
                cur_nin  = CNT_W'(LAYER_W[l]);
                cur_nout = CNT_W'(LAYER_W[l+1]);
                cur_wb   = w_base(l);
                cur_bb   = b_base(l);
            end
        end
    end

    // Step flags and flat table indices.
    always_comb begin
        load     = start && !busy;
        first    = busy && (inp == '0);
        last     = busy && (inp == cur_nin - CNT_W'(1));
        last_nrn = (nrn == cur_nout - CNT_W'(1));
        last_lyr = (lyr == LYR_W'(NUM_LAYERS - 1));
        w_idx    = WIDX_W'(cur_wb) + WIDX_W'(nrn) * WIDX_W'(cur_nin) + WIDX_W'(inp);
        b_idx    = BIDX_W'(cur_bb) + BIDX_W'(nrn);
    end

    // Advance the nested counters and raise done after the final store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            lyr  <= '0;
            nrn  <= '0;
            inp  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    lyr  <= '0;
                    nrn  <= '0;
                    inp  <= '0;
                end
            end else if (!last) begin
                inp <= inp + CNT_W'(1);
            end else begin
                inp <= '0;
                if (!last_nrn) begin
                    nrn <= nrn + CNT_W'(1);
                end else begin
                    nrn <= '0;
                    if (last_lyr) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        lyr  <= '0;
                    end else begin
                        lyr <= lyr + LYR_W'(1);
                    end
                end
            end
        end
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && lyr == '0 && nrn == '0 && inp == '0));
    assert_done_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
    assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> (inp == $past(inp) + CNT_W'(1)));
endmodule

// File: rtl/nnseq_mac.sv
// Shared multiply-accumulate with power-of-two weight restore, bias add and
// saturating rectifier. Assumes weights arrive divided by 2**WSHIFT.
module nnseq_mac
    import nnseq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic                     first,
    input  logic                     last,
    input  logic signed [DATA_W-1:0] din,
    input  logic signed [WQ_W-1:0]   wq,
    input  logic signed [BIAS_W-1:0] bias,
    output logic signed [DATA_W-1:0] act_out
);
    localparam int PROD_W = DATA_W + WQ_W;
    localparam logic signed [ACC_W-1:0] ACT_LIM = ACC_W'(ACT_MAX);

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext, base, sum, pre, scaled, acc_q;

    // Narrow product, widened and shifted back to true scale, then summed.
    always_comb begin
        prod     = din * wq;
        prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod} <<< WSHIFT;
        base     = first ? '0 : acc_q;
        sum      = base + prod_ext;
        pre      = sum + {{(ACC_W-BIAS_W){bias[BIAS_W-1]}}, bias};
        scaled   = pre >>> ACT_SHIFT;
        if (scaled < 0)            act_out = '0;
        else if (scaled > ACT_LIM) act_out = DATA_W'(ACT_MAX);
        else                       act_out = scaled[DATA_W-1:0];
    end

    // Accumulator register, updated on every sequencer step.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (step) acc_q <= sum;
    end

    assert_acc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && first) |=> (acc_q == $past(prod_ext)));
    assert_act_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |-> !act_out[DATA_W-1]);
endmodule

// File: rtl/nnseq_bank.sv
// Input latch plus two alternating layer register banks. Layer 0 reads the
// latch; layer l reads the bank written by layer l-1. Assumes read and write
// never target the same bank within one layer.
module nnseq_bank
    import nnseq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [NUM_IN*DATA_W-1:0]  x_flat,
    input  logic [LYR_W-1:0]          lyr,
    input  logic [CNT_W-1:0]          inp,
    input  logic                      wr_en,
    input  logic [CNT_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    output logic signed [DATA_W-1:0]  rd_data,
    output logic [NUM_OUT*DATA_W-1:0] y_flat
);
    localparam int FIN = (NUM_LAYERS - 1) % 2;

    logic [DATA_W-1:0] cap_q  [MAX_W];
    logic [DATA_W-1:0] bank_q [2][MAX_W];
    logic              wr_sel;

    // Layer parity picks the write bank; the read bank is the other one.
    always_comb begin
        wr_sel = lyr[0];
        if (lyr == '0) rd_data = cap_q[inp[RD_W-1:0]];
        else           rd_data = bank_q[~lyr[0]][inp[RD_W-1:0]];
    end

    // Latch primary inputs at start and store neuron results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_W; i++) begin
                cap_q[i]     <= '0;
                bank_q[0][i] <= '0;
                bank_q[1][i] <= '0;
            end
        end else begin
            if (load) begin
                for (int i = 0; i < NUM_IN; i++) cap_q[i] <= x_flat[i*DATA_W +: DATA_W];
            end
            if (wr_en) bank_q[wr_sel][wr_idx[RD_W-1:0]] <= wr_data;
        end
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        assign y_flat[k*DATA_W +: DATA_W] = bank_q[FIN][k];
    end

    assert_wr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < CNT_W'(MAX_W)));
endmodule

// File: rtl/mac_net_seq.sv
// Top: whole feedforward network on one MAC. Holds the constant weight and
// bias tables and wires sequencer, datapath and layer banks together.
module mac_net_seq
    import nnseq_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [nnseq_pkg::NUM_IN*8-1:0]    x_in,
    output logic [nnseq_pkg::NUM_OUT*8-1:0]   y_out,
    output logic                              done
);
    logic                     busy, load, first, last;
    logic [LYR_W-1:0]         lyr;
    logic [CNT_W-1:0]         nrn, inp;
    logic [WIDX_W-1:0]        w_idx;
    logic [BIDX_W-1:0]        b_idx;
    logic signed [DATA_W-1:0] rd_data, act_out;
    logic signed [WQ_W-1:0]   wtab [TOTAL_W];
    logic signed [BIAS_W-1:0] btab [TOTAL_B];

    for (genvar g = 0; g < TOTAL_W; g++) begin : g_wtab
        assign wtab[g] = WQ_W'(stored_weight(g));
    end
    for (genvar g = 0; g < TOTAL_B; g++) begin : g_btab
        assign btab[g] = BIAS_W'(bias_val(g));
    end

    nnseq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .load(load),
        .lyr(lyr), .nrn(nrn), .inp(inp), .first(first), .last(last),
        .w_idx(w_idx), .b_idx(b_idx), .done(done)
    );

    nnseq_mac u_mac (
        .clk(clk), .rst_n(rst_n), .step(busy), .first(first), .last(last),
        .din(rd_data), .wq(wtab[w_idx]), .bias(btab[b_idx]), .act_out(act_out)
    );

    nnseq_bank u_bank (
        .clk(clk), .rst_n(rst_n), .load(load), .x_flat(x_in), .lyr(lyr),
        .inp(inp), .wr_en(last), .wr_idx(nrn), .wr_data(act_out),
        .rd_data(rd_data), .y_flat(y_out)
    );
endmodule

// File: tb/mac_net_seq_test.sv
// Bench: table of stimulus vectors checked against an integer model that uses
// full-scale weights, then random vectors and directed corner cases.
module mac_net_seq_test;
    import nnseq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] x_in = '0;
    logic [15:0] y_out;
    logic        done;
    int          tests = 0;
    int          fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    mac_net_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
                     .y_out(y_out), .done(done));

    localparam logic [31:0] STIM [8] = '{
        32'h7F7F7F7F, 32'h80808080, 32'h00000000, 32'h01020304,
        32'hF0107F80, 32'h40C02080, 32'h7F00807F, 32'h10203040 };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model (R5, R6: true weight = stored weight * 2**WSHIFT).
    function automatic logic [15:0] ref_net(input logic [31:0] xv);
        int a [4];
        int nx [4];
        logic [15:0] r;
        for (int i = 0; i < 4; i++) a[i] = int'($signed(xv[i*8 +: 8]));
        for (int l = 0; l < NUM_LAYERS; l++) begin
            for (int n = 0; n < LAYER_W[l+1]; n++) begin
                int s;
                s = bias_val(b_base(l) + n);
                for (int i = 0; i < LAYER_W[l]; i++)
                    s += a[i] * (stored_weight(w_base(l) + n*LAYER_W[l] + i) * (1 << WSHIFT));
                s = s >>> ACT_SHIFT;
                if (s < 0) s = 0;
                if (s > 127) s = 127;
                nx[n] = s;
            end
            for (int i = 0; i < 4; i++) a[i] = nx[i];
        end
        for (int k = 0; k < 2; k++) r[k*8 +: 8] = 8'(a[k]);
        return r;
    endfunction

    // One run; optionally disturbs x_in and start mid-run (R3, R4).
    task automatic run_one(input logic [31:0] xv, input bit disturb, input logic [31:0] xalt,
                           output logic [15:0] yo, output int lat, output int pulses);
        @(negedge clk);
        x_in = xv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = -1;
        pulses = 0;
        yo = '0;
        for (int k = 1; k <= RUN_CYCLES + 6; k++) begin
            if (disturb && k == 5) begin
                x_in = xalt;
                start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (done) begin
                pulses++;
                if (lat < 0) begin
                    lat = k;
                    yo = y_out;
                end
            end
        end
    endtask

    task automatic vec_test(input logic [31:0] xv, input string tag);
        logic [15:0] yo, ex;
        int lat, pulses;
        run_one(xv, 1'b0, '0, yo, lat, pulses);
        ex = ref_net(xv);
        check(lat == RUN_CYCLES, {"R2 latency ", tag}, lat, RUN_CYCLES);
        check(pulses == 1, {"R2 pulse count ", tag}, pulses, 1);
        check(yo == ex, {"R5 R6 R8 outputs ", tag}, yo, ex);
    endtask

    initial begin
        logic [15:0] yo, ex, hold;
        int lat, pulses;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(y_out == '0, "R1 outputs after reset", y_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && y_out == '0, "R1 idle without start", y_out, 0);

        // Table walk: saturation ends, zero, mixed patterns
        foreach (STIM[i]) vec_test(STIM[i], $sformatf("table%0d", i));

        // Random vectors against the model
        for (int i = 0; i < 16; i++) vec_test($urandom, $sformatf("rand%0d", i));

        // R3/R4: x_in change and start pulse mid-run are ignored
        run_one(32'h7F7F7F7F, 1'b1, 32'h80808080, yo, lat, pulses);
        ex = ref_net(32'h7F7F7F7F);
        check(lat == RUN_CYCLES, "R4 latency with mid-run start", lat, RUN_CYCLES);
        check(pulses == 1, "R4 single done pulse", pulses, 1);
        check(yo == ex, "R3 latched inputs used", yo, ex);

        // R7: large run followed by small run, then the small one repeated
        run_one(32'h7F7F7F7F, 1'b0, '0, yo, lat, pulses);
        run_one(32'h01020304, 1'b0, '0, yo, lat, pulses);
        ex = ref_net(32'h01020304);
        check(yo == ex, "R7 accumulator clears after large run", yo, ex);
        run_one(32'h01020304, 1'b0, '0, hold, lat, pulses);
        check(hold == yo, "R7 repeated run identical", hold, yo);

        // R9: outputs hold after done while idle, even with x_in changing
        x_in = 32'h55AA55AA;
        repeat (20) @(negedge clk);
        check(y_out == hold, "R9 outputs held after done", y_out, hold);
        check(done == 1'b0, "R9 done stays low while idle", done, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 20000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule